// File: doc/BRIEF.md
# UART Register Front-End with Prioritized Interrupt Identification

This block sits between a host bus and the serial engine of a PC-style UART. It decodes a 3-bit register address under single-cycle read and write strobes. It holds the configuration state: the interrupt mask, the line format and control, the modem control, a scratch byte and the 16-bit baud divisor. It also turns status events from the receiver, the transmitter and the modem inputs into one interrupt line and an identification byte. The bit shifting itself lives elsewhere. That engine reports a received byte, line errors, a holding-register-empty event and shift-register idle on plain inputs. It receives the byte the host writes for transmission through a load strobe.

The host sees four interrupt sources at fixed priority. Each is acknowledged by a different access. Reading the status byte clears line errors. Reading the receive buffer clears data-available. Reading the modem status clears modem changes. The transmit-empty source clears when the identification byte is read while it reports that source, or when a byte is written for transmission. When the divisor-access bit (bit 7 of the line control byte) is set, addresses 0 and 1 reach the divisor low and high bytes instead of the data and mask registers.

Top module: `uart_regfront`

## Requirements
- R1: After reset the identification byte reads 0x01 and irq is low. The mask, line control, modem control, scratch, line status bits 5:0, modem status and the divisor all read zero.
- R2: The line control byte and the scratch byte (address 7) read back all 8 bits as written. The interrupt mask (address 1) keeps bits 3:0 and reads bits 7:4 as zero. The modem control byte (address 4) keeps bits 4:0 and reads bits 7:5 as zero.
- R3: With line control bit 7 set, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8. Such writes neither strobe tx_load nor change the interrupt mask.
- R4: Mask bit 0 enables data-available, bit 1 transmit-empty, bit 2 line-status and bit 3 modem-status. A masked source neither raises irq nor shows in the identification byte. irq is high exactly when some enabled source is pending.
- R5: The identification byte (address 2) reads 0x06 for line status, 0x04 for data available, 0x02 for transmit empty and 0x00 for modem status. It always names the highest pending enabled source in that order. Bit 0 is 1 only when nothing is pending, and bits 7:3 read zero.
- R6: line_err bits {3:break, 2:framing, 1:parity, 0:overrun} set status bits 4:1 and hold them. A status read (address 5) returns them and then clears them. A line-status interrupt is pending while any of the four is set.
- R7: rx_valid captures rx_byte and sets status bit 0. A read of address 0 with bit 7 of line control clear returns the byte and clears status bit 0.
- R8: A thr_empty pulse sets status bit 5 and the transmit-empty interrupt. An identification read that returns 0x02 clears that interrupt but leaves bit 5 set, and an identification read returning any other code leaves it pending. A write to address 0 with divisor access off strobes tx_load with the written byte and clears both.
- R9: Each modem input {3:carrier detect, 2:ring, 1:data set ready, 0:clear to send} appears in modem status bits 7:4 one clock later. A change on an input sets the matching bit in 3:0. A read of address 6 clears bits 3:0.
- R10: Modem control bits 0 to 4 are DTR, RTS, OUT1, OUT2 and loopback, driven on modem_out as {OUT2, OUT1, RTS, DTR}. In loopback, modem_out is forced to zero and the modem status inputs come from RTS (clear to send), DTR (data set ready), OUT1 (ring) and OUT2 (carrier detect).
- R11: Status bit 6 follows tx_idle, and status bit 7 reads zero.
- R12: An event that sets a status bit in the same cycle as the read that would clear it wins: the bit stays set after the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| rd | input | 1 | Read strobe, side effects on the clock edge |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Receiver delivered a byte |
| rx_byte | input | 8 | Received byte |
| line_err | input | 4 | Error pulses {break, framing, parity, overrun} |
| thr_empty | input | 1 | Holding register moved into the shift register |
| tx_idle | input | 1 | Shift register empty |
| tx_load | output | 1 | Host wrote a byte for transmission |
| tx_data | output | 8 | Byte to transmit, valid with tx_load |
| modem_in | input | 4 | {carrier detect, ring, data set ready, clear to send} |
| modem_out | output | 4 | {OUT2, OUT1, RTS, DTR} |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control byte |

## Verification
The bench aims at the acknowledge rules, because each source clears through a different access. An identification read that cleared transmit-empty while reporting another source would make that interrupt vanish unserviced. A status read that did not clear errors would hold irq high forever. The bench also drives the aliasing at addresses 0 and 1, where a design that leaked a divisor write into the mask or the transmit strobe would corrupt the mask or send a stray byte. It covers a new byte landing in the same cycle as the buffer read, where a design that let the clear win would lose the data-ready flag. Loopback is checked for the exact bit mapping and for modem_out being forced to zero.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int DW     = 8;
    localparam int AW     = 3;
    localparam int NSRC   = 4;
    localparam int DIV_W  = 2 * DW;

    typedef enum logic [AW-1:0] {
        A_DATA = 3'd0,
        A_MASK = 3'd1,
        A_IDENT = 3'd2,
        A_LCTL = 3'd3,
        A_MCTL = 3'd4,
        A_LSTAT = 3'd5,
        A_MSTAT = 3'd6,
        A_SCRATCH = 3'd7
    } rf_addr_e;

    // index into the pending vector equals the identification code
    typedef enum logic [1:0] {
        SRC_MODEM = 2'b00,
        SRC_TXE   = 2'b01,
        SRC_RXD   = 2'b10,
        SRC_LINE  = 2'b11
    } int_src_e;

    typedef struct packed {
        logic rbr_rd;
        logic thr_wr;
        logic txe_ack;
        logic lsr_rd;
        logic msr_rd;
    } side_fx_t;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mctl_t;

    function automatic logic [DW-1:0] ident_code(input logic [NSRC-1:0] pend);
        logic [DW-1:0] code;
        code = 8'h01;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i]) code = {5'b0, 2'(i), 1'b0};
        end
        return code;
    endfunction

endpackage

// File: rtl/uart_rf_cfg.sv
module uart_rf_cfg
    import uart_rf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    output logic [NSRC-1:0]  ier,
    output logic [DW-1:0]    lcr,
    output mctl_t            mcr,
    output logic [DW-1:0]    scr,
    output logic [DIV_W-1:0] divisor
);
    logic dlab;
    assign dlab = lcr[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ier     <= '0;
            lcr     <= '0;
            mcr     <= '0;
            scr     <= '0;
            divisor <= '0;
        end else if (wr) begin
            case (rf_addr_e'(addr))
                A_DATA:    if (dlab) divisor[DW-1:0] <= wdata;
                A_MASK: begin
                    if (dlab) divisor[DIV_W-1:DW] <= wdata;
                    else      ier <= wdata[NSRC-1:0];
                end
                A_LCTL:    lcr <= wdata;
                A_MCTL:    mcr <= mctl_t'(wdata[$bits(mctl_t)-1:0]);
                A_SCRATCH: scr <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_rf_stat.sv
module uart_rf_stat
    import uart_rf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  side_fx_t        fx,
    input  logic            rx_valid,
    input  logic [DW-1:0]   rx_byte,
    input  logic [3:0]      line_err,
    input  logic            thr_empty,
    input  logic [3:0]      modem_in,
    input  mctl_t           mcr,
    output logic [DW-1:0]   rbr,
    output logic            data_rdy,
    output logic [3:0]      errs,
    output logic            thre,
    output logic            txe_flag,
    output logic [DW-1:0]   msr
);
    logic [3:0] pins_eff, pins_q, delta;

    // loopback: {dcd, ri, dsr, cts} <= {out2, out1, dtr, rts}
    assign pins_eff = mcr.loop ? {mcr.out2, mcr.out1, mcr.dtr, mcr.rts} : modem_in;
    assign msr      = {pins_q, delta};

    always_ff @(posedge clk) begin
        if (rst) begin
            rbr      <= '0;
            data_rdy <= 1'b0;
            errs     <= '0;
            thre     <= 1'b0;
            txe_flag <= 1'b0;
            pins_q   <= '0;
            delta    <= '0;
        end else begin
            if (rx_valid) begin
                rbr      <= rx_byte;
                data_rdy <= 1'b1;
            end else if (fx.rbr_rd) begin
                data_rdy <= 1'b0;
            end

            errs <= (fx.lsr_rd ? 4'b0 : errs) | line_err;

            if (thr_empty)      thre <= 1'b1;
            else if (fx.thr_wr) thre <= 1'b0;

            if (thr_empty)                     txe_flag <= 1'b1;
            else if (fx.thr_wr || fx.txe_ack)  txe_flag <= 1'b0;

            pins_q <= pins_eff;
            delta  <= (fx.msr_rd ? 4'b0 : delta) | (pins_eff ^ pins_q);
        end
    end
endmodule

// File: rtl/uart_rf_intc.sv
module uart_rf_intc
    import uart_rf_pkg::*;
(
    input  logic [NSRC-1:0] ier,
    input  logic [3:0]      errs,
    input  logic            data_rdy,
    input  logic            txe_flag,
    input  logic [3:0]      delta,
    output logic [NSRC-1:0] pend,
    output logic            irq,
    output logic [DW-1:0]   iir
);
    always_comb begin
        pend            = '0;
        pend[SRC_LINE]  = ier[2] && (|errs);
        pend[SRC_RXD]   = ier[0] && data_rdy;
        pend[SRC_TXE]   = ier[1] && txe_flag;
        pend[SRC_MODEM] = ier[3] && (|delta);
    end

    assign irq = |pend;
    assign iir = ident_code(pend);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             rd,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_byte,
    input  logic [3:0]       line_err,
    input  logic             thr_empty,
    input  logic             tx_idle,
    output logic             tx_load,
    output logic [DW-1:0]    tx_data,
    input  logic [3:0]       modem_in,
    output logic [3:0]       modem_out,
    output logic [DIV_W-1:0] divisor,
    output logic [DW-1:0]    line_ctrl
);
    logic [NSRC-1:0] ier_q, pend;
    logic [DW-1:0]   lcr_q, scr_q, rbr_q, msr_w, iir_w, lsr_w;
    mctl_t           mcr_q;
    logic            dlab, data_rdy, thre, txe_flag, loop_on;
    logic [3:0]      errs;
    side_fx_t        fx;

    assign dlab    = lcr_q[DW-1];
    assign loop_on = mcr_q.loop;

    always_comb begin
        fx         = '0;
        fx.rbr_rd  = rd && (addr == A_DATA) && !dlab;
        fx.thr_wr  = wr && (addr == A_DATA) && !dlab;
        fx.txe_ack = rd && (addr == A_IDENT) && (iir_w == 8'h02);
        fx.lsr_rd  = rd && (addr == A_LSTAT);
        fx.msr_rd  = rd && (addr == A_MSTAT);
    end

    uart_rf_cfg u_cfg (
        .clk(clk), .rst(rst), .addr(addr), .wr(wr), .wdata(wdata),
        .ier(ier_q), .lcr(lcr_q), .mcr(mcr_q), .scr(scr_q), .divisor(divisor)
    );

    uart_rf_stat u_stat (
        .clk(clk), .rst(rst), .fx(fx), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .line_err(line_err), .thr_empty(thr_empty), .modem_in(modem_in),
        .mcr(mcr_q), .rbr(rbr_q), .data_rdy(data_rdy), .errs(errs),
        .thre(thre), .txe_flag(txe_flag), .msr(msr_w)
    );

    uart_rf_intc u_intc (
        .ier(ier_q), .errs(errs), .data_rdy(data_rdy), .txe_flag(txe_flag),
        .delta(msr_w[3:0]), .pend(pend), .irq(irq), .iir(iir_w)
    );

    assign lsr_w = {1'b0, tx_idle, thre, errs, data_rdy};

    always_comb begin
        case (rf_addr_e'(addr))
            A_DATA:    rdata = dlab ? divisor[DW-1:0] : rbr_q;
            A_MASK:    rdata = dlab ? divisor[DIV_W-1:DW] : {4'b0, ier_q};
            A_IDENT:   rdata = iir_w;
            A_LCTL:    rdata = lcr_q;
            A_MCTL:    rdata = {3'b0, mcr_q};
            A_LSTAT:   rdata = lsr_w;
            A_MSTAT:   rdata = msr_w;
            default:   rdata = scr_q;
        endcase
    end

    assign tx_load   = fx.thr_wr;
    assign tx_data   = wdata;
    assign line_ctrl = lcr_q;
    assign modem_out = loop_on ? 4'b0 : {mcr_q.out2, mcr_q.out1, mcr_q.rts, mcr_q.dtr};
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
    import uart_rf_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   addr,
    input logic            rd,
    input logic            wr,
    input logic            irq,
    input logic [DW-1:0]   iir,
    input logic [DW-1:0]   lsr,
    input logic [3:0]      line_err,
    input logic            rx_valid,
    input logic            dlab,
    input logic [NSRC-1:0] ier,
    input logic            loop,
    input logic [3:0]      modem_out
);
    p_idle_code_r5: assert property (@(posedge clk) disable iff (rst)
        !irq |-> iir == 8'h01);

    // R4: a raised irq always comes with a pending code
    p_irq_code_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!iir[0] && iir[7:3] == 5'b0));

    p_line_top_r5: assert property (@(posedge clk) disable iff (rst)
        (ier[2] && lsr[4:1] != 4'b0) |-> iir == 8'h06);

    p_lsr_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == 3'd5 && line_err == 4'b0) |=> lsr[4:1] == 4'b0);

    p_rbr_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == 3'd0 && !dlab && !rx_valid) |=> !lsr[0]);

    p_dlab_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 3'd1 && dlab) |=> $stable(ier));

    p_loop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        loop |-> modem_out == 4'b0);
endmodule

bind uart_regfront uart_regfront_chk u_chk (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .irq(irq),
    .iir(iir_w), .lsr(lsr_w), .line_err(line_err), .rx_valid(rx_valid),
    .dlab(dlab), .ier(ier_q), .loop(loop_on), .modem_out(modem_out)
);

// File: tb/sim_uart_regfront.sv
`timescale 1ns/1ps
module sim_uart_regfront;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0, rdata;
    logic        irq;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [3:0]  line_err = '0;
    logic        thr_empty = 1'b0, tx_idle = 1'b0;
    logic        tx_load;
    logic [7:0]  tx_data;
    logic [3:0]  modem_in = '0, modem_out;
    logic [15:0] divisor;
    logic [7:0]  line_ctrl;

    int n_tests = 0, n_fail = 0, n_load = 0;
    logic [7:0] last_tx = '0;
    logic [7:0] v;
    bit done = 0;

    always #4 clk = ~clk;

    uart_regfront u0 (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .line_err(line_err), .thr_empty(thr_empty), .tx_idle(tx_idle),
        .tx_load(tx_load), .tx_data(tx_data), .modem_in(modem_in),
        .modem_out(modem_out), .divisor(divisor), .line_ctrl(line_ctrl)
    );

    always @(posedge clk) if (tx_load) begin
        n_load  <= n_load + 1;
        last_tx <= tx_data;
    end

    // {addr, write value, expected readback}
    localparam logic [18:0] VEC [0:7] = '{
        {3'd1, 8'hFF, 8'h0F},
        {3'd3, 8'h1B, 8'h1B},
        {3'd4, 8'hEF, 8'h0F},
        {3'd7, 8'hA5, 8'hA5},
        {3'd7, 8'h5A, 8'h5A},
        {3'd1, 8'h00, 8'h00},
        {3'd4, 8'h00, 8'h00},
        {3'd3, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] r;
        bus_rd(a, r);
        check(req, {8'h0, r}, {8'h0, exp});
    endtask

    task automatic pulse_rx(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pulse_err(input logic [3:0] e);
        @(negedge clk); line_err = e;
        @(negedge clk); line_err = '0;
    endtask

    task automatic pulse_thre();
        @(negedge clk); thr_empty = 1'b1;
        @(negedge clk); thr_empty = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1 check("R1 irq", {15'b0, irq}, 16'h0);
        check("R1 divisor", divisor, 16'h0);
        read_chk("R1 ident", 3'd2, 8'h01);
        read_chk("R1 mask", 3'd1, 8'h00);
        read_chk("R1 lctl", 3'd3, 8'h00);
        read_chk("R1 mctl", 3'd4, 8'h00);
        read_chk("R1 lstat", 3'd5, 8'h00);
        read_chk("R1 mstat", 3'd6, 8'h00);
        read_chk("R1 scratch", 3'd7, 8'h00);

        // R2 readback table
        for (int i = 0; i < 8; i++) begin
            bus_wr(VEC[i][18:16], VEC[i][15:8]);
            read_chk("R2 readback", VEC[i][18:16], VEC[i][7:0]);
        end

        // R3 divisor aliasing
        bus_wr(3'd3, 8'h80);
        bus_wr(3'd0, 8'h34);
        bus_wr(3'd1, 8'h12);
        #1 check("R3 divisor", divisor, 16'h1234);
        check("R3 line_ctrl", {8'h0, line_ctrl}, 16'h0080);
        check("R3 no tx_load", n_load[15:0], 16'h0);
        read_chk("R3 div lo", 3'd0, 8'h34);
        read_chk("R3 div hi", 3'd1, 8'h12);
        bus_wr(3'd3, 8'h03);
        read_chk("R3 mask untouched", 3'd1, 8'h00);

        // R5 R8 R6 R7 priority walk
        bus_wr(3'd1, 8'h0F);
        pulse_thre();
        #1 check("R8 irq", {15'b0, irq}, 16'h1);
        read_chk("R8 lstat thre", 3'd5, 8'h20);
        pulse_rx(8'hC3);
        read_chk("R5 rxd over txe", 3'd2, 8'h04);
        pulse_err(4'b0010);
        read_chk("R5 line highest", 3'd2, 8'h06);
        read_chk("R6 lstat errs", 3'd5, 8'h25);
        read_chk("R6 errs cleared", 3'd5, 8'h21);
        read_chk("R5 back to rxd", 3'd2, 8'h04);
        read_chk("R7 rbr", 3'd0, 8'hC3);
        read_chk("R7 dr cleared", 3'd5, 8'h20);
        read_chk("R8 ident txe", 3'd2, 8'h02);
        read_chk("R8 txe acked", 3'd2, 8'h01);
        #1 check("R8 irq low", {15'b0, irq}, 16'h0);
        read_chk("R8 thre kept", 3'd5, 8'h20);
        bus_wr(3'd0, 8'h77);
        #1 check("R8 tx_load count", n_load[15:0], 16'h1);
        check("R8 tx_data", {8'h0, last_tx}, 16'h0077);
        read_chk("R8 thre cleared", 3'd5, 8'h00);

        // R8 ident read reporting another source keeps txe
        pulse_thre();
        pulse_rx(8'h11);
        read_chk("R8 ident rxd", 3'd2, 8'h04);
        read_chk("R7 rbr 2", 3'd0, 8'h11);
        read_chk("R8 txe survives", 3'd2, 8'h02);
        bus_wr(3'd0, 8'h00);
        read_chk("R8 write clears", 3'd2, 8'h01);

        // R4 masking
        bus_wr(3'd1, 8'h00);
        pulse_err(4'b1000);
        #1 check("R4 masked irq", {15'b0, irq}, 16'h0);
        read_chk("R4 masked ident", 3'd2, 8'h01);
        bus_wr(3'd1, 8'h04);
        #1 check("R4 enabled irq", {15'b0, irq}, 16'h1);
        read_chk("R6 break bit", 3'd5, 8'h10);
        #1 check("R4 irq after clear", {15'b0, irq}, 16'h0);

        // R9 modem status
        bus_wr(3'd1, 8'h08);
        @(negedge clk); modem_in = 4'b0001;
        @(negedge clk);
        #1 check("R9 irq", {15'b0, irq}, 16'h1);
        read_chk("R5 modem code", 3'd2, 8'h00);
        read_chk("R9 msr delta", 3'd6, 8'h11);
        read_chk("R9 msr cleared", 3'd6, 8'h10);
        read_chk("R9 ident idle", 3'd2, 8'h01);
        @(negedge clk); modem_in = 4'b0000;
        read_chk("R9 msr fall", 3'd6, 8'h01);

        // R10 loopback
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd4, 8'h13);
        #1 check("R10 out forced", {12'b0, modem_out}, 16'h0);
        read_chk("R10 loop status", 3'd6, 8'h33);
        bus_wr(3'd4, 8'h0E);
        #1 check("R10 out normal", {12'b0, modem_out}, 16'h000E);
        bus_wr(3'd4, 8'h00);
        read_chk("R10 clear msr", 3'd6, 8'h03);

        // R11 tx idle
        @(negedge clk); tx_idle = 1'b1;
        read_chk("R11 idle bit", 3'd5, 8'h40);

        // R12 set wins over clear
        bus_wr(3'd1, 8'h01);
        pulse_rx(8'hAA);
        @(negedge clk); addr = 3'd0; rd = 1'b1; rx_valid = 1'b1; rx_byte = 8'h55;
        #1 v = rdata;
        @(negedge clk); rd = 1'b0; rx_valid = 1'b0;
        check("R12 old byte", {8'h0, v}, 16'h00AA);
        #1 check("R12 irq held", {15'b0, irq}, 16'h1);
        read_chk("R12 dr held", 3'd5, 8'h41);
        read_chk("R12 new byte", 3'd0, 8'h55);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule